// File: doc/BRIEF.md
# Dual-Frame-Sync Converter Serial Port

This block is the device side of a serial port for a multi-channel data converter. The serial clock is driven from outside. A write-frame sync input and a read-frame sync input frame the two directions independently. A falling edge on the write sync starts a 10-bit control word shifting in from the data input on falling serial clock edges. A write frame lasts 13 clocks, but only the first 10 bits are kept. A rising edge on the read sync captures the latest parallel conversion result and arms a bit counter. The counter then launches the result, most significant bit first, on rising serial clock edges. The data output is released (output enable low) on the 11th rising edge.

A hardwired address pin is compared with the address bit of each completed control word, which lets two devices share one bus. A matching word is presented on a parallel port with a one-cycle valid strobe, and the device becomes selected. A word whose address bit does not match is discarded and deselects the device, so later reads leave the data pin released. All pins are sampled in a fast system clock domain. The serial clock and both syncs each pass through a two-flop synchronizer followed by an edge detector.

Top module: `dfsp_port`

## Requirements
- R1: While reset is asserted, and right after it is released, doutOe, ctrlValid and ctrlWord are all 0, and the device is deselected.
- R2: A falling edge on tfsIn starts a write. The data input is sampled on the following falling edges of sclkIn, and the first bit sampled ends up in ctrlWord[9].
- R3: Only the first 10 falling edges of a write frame shift data in. Falling edges 11 to 13 of the frame are ignored, and so are falling edges that arrive when no write frame is open.
- R4: When the 10th bit is captured and the word's bit 0 (the address bit) equals addrPin, ctrlWord takes the word, ctrlValid is high for exactly one cycle, and the device becomes selected.
- R5: When the address bit does not match, ctrlWord keeps its old value and ctrlValid stays low. The device is deselected, and doutOe stays low through subsequent reads until a matching word is written.
- R6: A rising edge on rfsIn loads resultIn. Changes on resultIn after that edge do not affect the bits sent in that read.
- R7: On the k-th rising edge of sclkIn after the rfsIn rise (k = 1..10), doutOut presents result bit 10-k, so bit 9 comes first. doutOe is high from the 1st rising edge if the device is selected.
- R8: On the 11th rising edge of a read, doutOe goes low.
- R9: After a read ends, further sclkIn edges have no effect on doutOe until a new rising edge on rfsIn, even if rfsIn stays high and the clock keeps running.
- R10: ctrlWord[1] is the external-reference select and is reported exactly as written.
- R11: An output reacts on the third system clock edge after the pin change that causes it (two synchronizer stages plus one register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | External serial clock |
| tfsIn | input | 1 | Write-frame sync, active on falling edge |
| rfsIn | input | 1 | Read-frame sync, active on rising edge |
| dinIn | input | 1 | Serial control data in |
| addrPin | input | 1 | Hardwired package address |
| resultIn | input | 10 | Parallel conversion result |
| doutOut | output | 1 | Serial result data out |
| doutOe | output | 1 | Drive enable of the serial data pin |
| ctrlWord | output | 10 | Last accepted control word |
| ctrlValid | output | 1 | One-cycle strobe when ctrlWord updates |

## Verification
If the write counter is wrong, a word lands shifted or contaminated by trailer bits, and this shows on ctrlWord three cycles after the 10th falling edge. If the read counter is wrong, doutOe rises or falls on the wrong serial edge, or a free-running clock re-triggers the port without a new sync. A stale select flag leaves doutOe low, or high, on the first rising edge of the next read. Each of these departs from the bench's reference model within the same system clock cycle it occurs.

// File: rtl/dfsp_pkg.sv
package dfsp_pkg;
  localparam int DATA_BITS = 10;
  localparam int IDX_W     = $clog2(DATA_BITS);
  localparam int ADDR_POS  = 0;
  localparam int REF_POS   = 1;

  typedef struct packed {
    logic             wrShift;
    logic             wrCommit;
    logic             rdLoad;
    logic             rdDrive;
    logic             rdStop;
    logic [IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/dfsp_sync.sv
module dfsp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] lastOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= asyncIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastOut <= '0;
    else       lastOut <= stage[STAGES-1];

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/dfsp_ctrl.sv
module dfsp_ctrl
  import dfsp_pkg::*;
#(
  parameter int WR_CLKS = 13
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkS,
  input  logic    sclkD,
  input  logic    tfsS,
  input  logic    tfsD,
  input  logic    rfsS,
  input  logic    rfsD,
  output strobe_t st
);
  localparam int WCNT_W = $clog2(WR_CLKS + 1);
  localparam int RCNT_W = $clog2(DATA_BITS + 1);
  localparam logic [WCNT_W-1:0] WR_LAST = WCNT_W'(WR_CLKS - 1);
  localparam logic [WCNT_W-1:0] WR_DATA = WCNT_W'(DATA_BITS);
  localparam logic [RCNT_W-1:0] RD_DATA = RCNT_W'(DATA_BITS);

  logic              wrActive, rdActive;
  logic [WCNT_W-1:0] wrCnt;
  logic [RCNT_W-1:0] rdCnt;
  logic sclkRise, sclkFall, tfsFall, rfsRise;

  assign sclkRise = sclkS & ~sclkD;
  assign sclkFall = ~sclkS & sclkD;
  assign tfsFall  = ~tfsS & tfsD;
  assign rfsRise  = rfsS & ~rfsD;

  always_comb begin
    st.wrShift  = !tfsFall && sclkFall && wrActive && (wrCnt < WR_DATA);
    st.wrCommit = st.wrShift && (wrCnt == WR_DATA - 1'b1);
    st.rdLoad   = rfsRise;
    st.rdDrive  = !rfsRise && sclkRise && rdActive && (rdCnt < RD_DATA);
    st.rdStop   = !rfsRise && sclkRise && rdActive && (rdCnt == RD_DATA);
    st.bitIdx   = IDX_W'(DATA_BITS - 1) - IDX_W'(rdCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActive <= 1'b0;
      wrCnt    <= '0;
    end else if (tfsFall) begin
      wrActive <= 1'b1;
      wrCnt    <= '0;
    end else if (sclkFall && wrActive) begin
      if (wrCnt == WR_LAST) begin
        wrActive <= 1'b0;
        wrCnt    <= '0;
      end else begin
        wrCnt <= wrCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdCnt    <= '0;
    end else if (rfsRise) begin
      rdActive <= 1'b1;
      rdCnt    <= '0;
    end else if (st.rdDrive) begin
      rdCnt <= rdCnt + 1'b1;
    end else if (st.rdStop) begin
      rdActive <= 1'b0;
      rdCnt    <= '0;
    end
  end

  assert_wrcnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= WR_LAST);
  assert_rdcnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt <= RD_DATA);
  assert_idle_no_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdActive && !rfsRise) |=> (rdCnt == '0));
endmodule

// File: rtl/dfsp_data.sv
module dfsp_data
  import dfsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic                 dinS,
  input  logic                 addrPin,
  input  logic [DATA_BITS-1:0] resultIn,
  output logic                 doutOut,
  output logic                 doutOe,
  output logic [DATA_BITS-1:0] ctrlWord,
  output logic                 ctrlValid
);
  logic [DATA_BITS-1:0] wrReg, nextWord, resHold;
  logic                 selected;

  assign nextWord = {wrReg[DATA_BITS-2:0], dinS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReg     <= '0;
      ctrlWord  <= '0;
      ctrlValid <= 1'b0;
      selected  <= 1'b0;
      resHold   <= '0;
      doutOut   <= 1'b0;
      doutOe    <= 1'b0;
    end else begin
      ctrlValid <= 1'b0;
      if (st.wrShift) wrReg <= nextWord;
      if (st.wrCommit) begin
        if (nextWord[ADDR_POS] == addrPin) begin
          ctrlWord  <= nextWord;
          ctrlValid <= 1'b1;
          selected  <= 1'b1;
        end else begin
          selected <= 1'b0;
        end
      end
      if (st.rdLoad) begin
        resHold <= resultIn;
        doutOe  <= 1'b0;
      end else if (st.rdDrive) begin
        doutOut <= resHold[st.bitIdx];
        doutOe  <= selected;
      end else if (st.rdStop) begin
        doutOut <= 1'b0;
        doutOe  <= 1'b0;
      end
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid |=> !ctrlValid);
  assert_oe_needs_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutOe) |-> $past(selected));
  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdLoad |=> $stable(resHold));
  assert_oe_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.rdStop |=> !doutOe);
endmodule

// File: rtl/dfsp_port.sv
module dfsp_port
  import dfsp_pkg::*;
#(
  parameter int WR_CLKS     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 tfsIn,
  input  logic                 rfsIn,
  input  logic                 dinIn,
  input  logic                 addrPin,
  input  logic [DATA_BITS-1:0] resultIn,
  output logic                 doutOut,
  output logic                 doutOe,
  output logic [DATA_BITS-1:0] ctrlWord,
  output logic                 ctrlValid
);
  logic [3:0] pinSync, pinLast;
  strobe_t    st;

  dfsp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({dinIn, rfsIn, tfsIn, sclkIn}),
    .syncOut (pinSync),
    .lastOut (pinLast)
  );

  dfsp_ctrl #(.WR_CLKS(WR_CLKS)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclkS (pinSync[0]),
    .sclkD (pinLast[0]),
    .tfsS  (pinSync[1]),
    .tfsD  (pinLast[1]),
    .rfsS  (pinSync[2]),
    .rfsD  (pinLast[2]),
    .st    (st)
  );

  dfsp_data uData (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .dinS      (pinSync[3]),
    .addrPin   (addrPin),
    .resultIn  (resultIn),
    .doutOut   (doutOut),
    .doutOe    (doutOe),
    .ctrlWord  (ctrlWord),
    .ctrlValid (ctrlValid)
  );
endmodule

// File: tb/dfsp_port_test.sv
`timescale 1ns/1ps
module dfsp_port_test;
  localparam int HP = 4;

  logic clk = 0, rstN = 0;
  logic sclkIn = 0, tfsIn = 1, rfsIn = 0, dinIn = 0, addrPin = 1;
  logic [9:0] resultIn = '0;
  logic doutOut, doutOe, ctrlValid;
  logic [9:0] ctrlWord;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dfsp_port uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .tfsIn(tfsIn), .rfsIn(rfsIn),
    .dinIn(dinIn), .addrPin(addrPin), .resultIn(resultIn), .doutOut(doutOut),
    .doutOe(doutOe), .ctrlWord(ctrlWord), .ctrlValid(ctrlValid)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // behavioural reference model
  int mS1, mS2, mS3, mT1 = 0, mT2 = 0, mT3 = 0, mR1, mR2, mR3, mD1, mD2;
  int wrOn, wrN, bits, sel, rdOn, rdN, rdWord, mOe, mBit, mWord, mValid;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mS3 = 0; mT1 = 0; mT2 = 0; mT3 = 0;
      mR1 = 0; mR2 = 0; mR3 = 0; mD1 = 0; mD2 = 0;
      wrOn = 0; wrN = 0; bits = 0; sel = 0; rdOn = 0; rdN = 0; rdWord = 0;
      mOe = 0; mBit = 0; mWord = 0; mValid = 0;
    end else begin
      mValid = 0;
      if (mT3 == 1 && mT2 == 0) begin
        wrOn = 1; wrN = 0;
      end else if (mS3 == 1 && mS2 == 0 && wrOn == 1) begin
        if (wrN < 10) begin
          bits = ((bits << 1) | mD2) & 1023;
          if (wrN == 9) begin
            if ((bits & 1) == int'(addrPin)) begin
              mWord = bits; mValid = 1; sel = 1;
            end else sel = 0;
          end
        end
        wrN++;
        if (wrN == 13) begin wrOn = 0; wrN = 0; end
      end
      if (mR2 == 1 && mR3 == 0) begin
        rdOn = 1; rdN = 0; rdWord = int'(resultIn); mOe = 0;
      end else if (mS2 == 1 && mS3 == 0 && rdOn == 1) begin
        if (rdN < 10) begin
          mBit = (rdWord >> (9 - rdN)) & 1; mOe = sel; rdN++;
        end else begin
          mOe = 0; mBit = 0; rdOn = 0; rdN = 0;
        end
      end
      mS3 = mS2; mS2 = mS1; mS1 = int'(sclkIn);
      mT3 = mT2; mT2 = mT1; mT1 = int'(tfsIn);
      mR3 = mR2; mR2 = mR1; mR1 = int'(rfsIn);
      mD2 = mD1; mD1 = int'(dinIn);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R4 ctrlValid vs model", int'(ctrlValid), mValid);
      check("R2 ctrlWord vs model", int'(ctrlWord), mWord);
      check("R8 doutOe vs model", int'(doutOe), mOe);
      if (mOe == 1) check("R7 doutOut vs model", int'(doutOut), mBit);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finishRun();
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclkIn = 1; waitN(HP);
    sclkIn = 0; waitN(HP);
  endtask

  task automatic writeWord(logic [9:0] w, logic trail, bit expCommit);
    tfsIn = 0; waitN(HP);
    for (int i = 0; i < 13; i++) begin
      dinIn = (i < 10) ? w[9-i] : trail;
      sclkIn = 1; waitN(HP);
      sclkIn = 0;
      if (i == 9 && expCommit) begin
        waitN(2);
        check("R11 ctrlValid low 2 cycles after edge", int'(ctrlValid), 0);
        waitN(1);
        check("R11 ctrlValid high 3 cycles after edge", int'(ctrlValid), 1);
        waitN(HP - 3);
      end else waitN(HP);
    end
    tfsIn = 1; waitN(HP);
  endtask

  task automatic readFrame(logic [9:0] res, int extra, output logic [9:0] got,
                           output int oeSeen, output int oeAfter);
    oeSeen = 0; oeAfter = 0; got = '0;
    resultIn = res;
    rfsIn = 1; waitN(HP);
    resultIn = ~res;
    for (int k = 1; k <= 10; k++) begin
      sclkIn = 1; waitN(3);
      got[10-k] = doutOut;
      if (doutOe) oeSeen = 1;
      waitN(1);
      sclkIn = 0; waitN(HP);
    end
    sclkIn = 1; waitN(3);
    oeAfter = int'(doutOe);
    waitN(1);
    sclkIn = 0; waitN(HP);
    for (int e = 0; e < extra; e++) begin
      sclkIn = 1; waitN(3);
      if (doutOe) oeAfter = 1;
      waitN(1);
      sclkIn = 0; waitN(HP);
    end
    rfsIn = 0; waitN(HP);
  endtask

  initial begin
    logic [9:0] got;
    int oeSeen, oeAfter;
    waitN(5);
    check("R1 doutOe in reset", int'(doutOe), 0);
    check("R1 ctrlWord in reset", int'(ctrlWord), 0);
    rstN = 1; waitN(4);
    check("R1 ctrlValid after reset", int'(ctrlValid), 0);

    writeWord(10'h2CD, 1'b1, 1);
    check("R2 first word MSB first", int'(ctrlWord), 'h2CD);

    writeWord(10'h1A3, 1'b0, 1);
    check("R3 trailer clocks ignored", int'(ctrlWord), 'h1A3);
    check("R10 ext reference bit", int'(ctrlWord[1]), 1);

    dinIn = 1;
    for (int p = 0; p < 12; p++) pulse();
    check("R3 falls without write frame", int'(ctrlWord), 'h1A3);

    readFrame(10'h2A5, 6, got, oeSeen, oeAfter);
    check("R7 read bits", int'(got), 'h2A5);
    check("R6 result held after load", int'(got), 'h2A5);
    check("R7 oe during read", oeSeen, 1);
    check("R8 oe low at 11th rise", oeAfter, 0);
    check("R9 free clock after read", oeAfter, 0);

    readFrame(10'h133, 0, got, oeSeen, oeAfter);
    check("R9 new sync rearms", int'(got), 'h133);

    writeWord(10'h0F0, 1'b1, 0);
    check("R5 mismatch keeps word", int'(ctrlWord), 'h1A3);
    readFrame(10'h155, 0, got, oeSeen, oeAfter);
    check("R5 deselected no drive", oeSeen, 0);

    addrPin = 0; waitN(2);
    writeWord(10'h0F2, 1'b1, 1);
    check("R4 match with pin low", int'(ctrlWord), 'h0F2);
    check("R10 ext reference bit set", int'(ctrlWord[1]), 1);
    readFrame(10'h3C1, 2, got, oeSeen, oeAfter);
    check("R4 reselected read", int'(got), 'h3C1);
    check("R4 reselected oe", oeSeen, 1);

    waitN(10);
    finishRun();
  end
endmodule